// File: doc/BRIEF.md
# Serial Hex Page Command Engine

This block sits between a byte-wide serial receiver and a byte-wide serial transmitter. It parses a strict ASCII command language and turns each command into operations on a word-organised, page-programmed memory. A command is one lowercase letter, four uppercase hex digits that give a 16-bit word address, and a carriage return. The command can erase a page, stream a page back as hex, load and commit a page of new data, or request a jump to an address. Malformed input is dropped without any reply, so the engine is always ready for the next command.

Characters arrive on a valid/ready stream. The engine raises `rx_ready` only while it is parsing, and holds it low while it talks to the memory or sends a reply. The sender therefore stalls instead of losing bytes. Replies leave on a second valid/ready stream. Once `tx_valid` is high, it stays high with `tx_data` unchanged until the cycle in which `tx_ready` is high. The memory side is a one-cycle request strobe with an operation code and an address. A request is never made while `mem_busy` is high. Read data must be present on `mem_rdata` in the cycle after a read request.

Top module: `hexpage_cmd_engine`

## Requirements
- R1: A carriage return (0x0D) received where a command letter is expected is consumed and ignored, and the engine keeps waiting for a command letter.
- R2: A line feed (0x0A) is consumed in every parsing position and changes nothing.
- R3: A character other than '0'-'9' or 'A'-'F' where a hex digit is expected ends the command. No memory request, reply or jump follows, and the next character is taken as a command letter.
- R4: A character other than a carriage return after the fourth address digit ends the command in the same silent way.
- R5: After 'r', address A and a carriage return, the engine issues PAGE_WORDS*2 read requests (mem_op 5) at byte addresses 2A+i for ascending i. It sends each returned byte as two uppercase hex characters, high nibble first, and then one '.'.
- R6: After 'w', address A and a carriage return, each group of four data digits forms one word. The first digit pair is the low byte. Each word is loaded (mem_op 2) at byte address 2(A+k) as soon as its fourth digit arrives, for k = 0 to PAGE_WORDS-1.
- R7: After the last data word, a carriage return leads to a commit (mem_op 3) at byte address 2A. Any other character ends the command with no commit and no reply.
- R8: A complete erase ('e', mem_op 1 at 2A) or write issues its erase or commit. It then issues a read re-enable (mem_op 4 at 2A) once the memory is idle, and only then sends '.'.
- R9: After 'g', address A and a carriage return, `jump_valid` is high for exactly one cycle with `jump_addr` = A. No memory request and no reply follow.
- R10: Any other letter followed by a well-formed address and a carriage return leaves the engine idle, with no memory request, reply or jump.
- R11: `mem_req` is never high while `mem_busy` is high.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold in the next cycle.
- R13: After reset, `rx_ready` is high and `tx_valid`, `mem_req` and `jump_valid` are low. `rx_ready` is never high in a cycle where `tx_valid` or `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received character present |
| rx_data | input | 8 | Received character |
| rx_ready | output | 1 | Engine accepts a character this cycle |
| tx_valid | output | 1 | Reply character present |
| tx_data | output | 8 | Reply character |
| tx_ready | input | 1 | Transmitter takes the character this cycle |
| mem_req | output | 1 | Memory operation strobe |
| mem_op | output | 3 | 1 erase, 2 load word, 3 commit, 4 read re-enable, 5 read byte |
| mem_addr | output | ADDR_W+1 | Byte address of the operation |
| mem_wdata | output | 16 | Word for a load |
| mem_rdata | input | 8 | Byte returned the cycle after a read request |
| mem_busy | input | 1 | Memory cannot take a request |
| jump_valid | output | 1 | One-cycle jump request |
| jump_addr | output | ADDR_W | Jump target word address |

## Verification
The bench builds the engine with PAGE_WORDS = 8 and the default 16-bit address. A write then needs only 32 data digits and a read returns 16 bytes. This makes room for many commands per run, including write aborts at every word position and at the closing carriage return. A random busy and a random transmit-ready pattern make the engine stall both before memory requests and in the middle of the hex stream. Bad characters are chosen at the edges of the hex ranges ('/', ':', '@', 'G', lowercase 'a' and 'f').

// File: rtl/hexpage_pkg.sv
package hexpage_pkg;

  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_LF  = 8'h0A;
  localparam logic [7:0] CH_DOT = 8'h2E;

  localparam logic [7:0] LTR_ERASE = 8'h65;  // 'e'
  localparam logic [7:0] LTR_READ  = 8'h72;  // 'r'
  localparam logic [7:0] LTR_WRITE = 8'h77;  // 'w'
  localparam logic [7:0] LTR_GO    = 8'h67;  // 'g'

  typedef enum logic [2:0] {
    MOP_NONE   = 3'd0,
    MOP_ERASE  = 3'd1,
    MOP_LOAD   = 3'd2,
    MOP_COMMIT = 3'd3,
    MOP_REEN   = 3'd4,
    MOP_READ   = 3'd5
  } mem_op_e;

  typedef enum logic [3:0] {
    ST_CMD,
    ST_ADDR,
    ST_ADDR_CR,
    ST_DATA,
    ST_LOAD,
    ST_DATA_CR,
    ST_ERASE,
    ST_COMMIT,
    ST_REEN,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_TX_HI,
    ST_TX_LO,
    ST_DOT
  } eng_state_e;

endpackage

// File: rtl/hexpage_hex_decode.sv
module hexpage_hex_decode (
  input  logic [7:0] ch,
  output logic       ok,
  output logic [3:0] val
);
  always_comb begin
    ok  = 1'b0;
    val = 4'h0;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      ok  = 1'b1;
      val = ch[3:0];
    end else if (ch >= 8'h41 && ch <= 8'h46) begin
      ok  = 1'b1;
      val = ch[3:0] + 4'd9;
    end
  end
endmodule

// File: rtl/hexpage_hex_encode.sv
module hexpage_hex_encode (
  input  logic [3:0] nib,
  output logic [7:0] ch
);
  always_comb begin
    if (nib < 4'd10) ch = 8'h30 + {4'h0, nib};
    else             ch = 8'h37 + {4'h0, nib};
  end
endmodule

// File: rtl/hexpage_cmd_engine.sv
module hexpage_cmd_engine
  import hexpage_pkg::*;
#(
  parameter int PAGE_WORDS = 32,
  parameter int ADDR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              mem_req,
  output logic [2:0]        mem_op,
  output logic [ADDR_W:0]   mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_busy,
  output logic              jump_valid,
  output logic [ADDR_W-1:0] jump_addr
);
  localparam int PAGE_BYTES = 2 * PAGE_WORDS;
  localparam int ADIG       = ADDR_W / 4;
  localparam int DCNT_W     = (ADIG > 4) ? $clog2(ADIG) : 2;
  localparam int WCNT_W     = $clog2(PAGE_WORDS);
  localparam int BCNT_W     = $clog2(PAGE_BYTES);
  localparam int BADDR_W    = ADDR_W + 1;

  eng_state_e        state;
  logic [7:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DCNT_W-1:0] dcnt;
  logic [WCNT_W-1:0] wcnt;
  logic [BCNT_W-1:0] bcnt;
  logic [15:0]       wacc;
  logic [7:0]        rbyte_q;
  logic              jump_q;

  logic       hex_ok;
  logic [3:0] hex_val;
  logic [7:0] enc_ch [2];
  logic       take;

  hexpage_hex_decode u_dec (.ch(rx_data), .ok(hex_ok), .val(hex_val));

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_enc
      hexpage_hex_encode u_enc (.nib(rbyte_q[4*g +: 4]), .ch(enc_ch[g]));
    end
  endgenerate

  assign rx_ready = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_ADDR_CR) ||
                    (state == ST_DATA) || (state == ST_DATA_CR);
  assign take     = rx_valid && rx_ready && (rx_data != CH_LF);

  assign tx_valid = (state == ST_TX_HI) || (state == ST_TX_LO) || (state == ST_DOT);

  always_comb begin
    case (state)
      ST_TX_HI: tx_data = enc_ch[1];
      ST_TX_LO: tx_data = enc_ch[0];
      default:  tx_data = CH_DOT;
    endcase
  end

  mem_op_e            op_c;
  logic               want_c;
  logic [BADDR_W-1:0] addr_c;

  always_comb begin
    op_c   = MOP_NONE;
    want_c = 1'b0;
    addr_c = {addr_q, 1'b0};
    case (state)
      ST_LOAD: begin
        want_c = 1'b1;
        op_c   = MOP_LOAD;
        addr_c = {addr_q + ADDR_W'(wcnt), 1'b0};
      end
      ST_ERASE:  begin want_c = 1'b1; op_c = MOP_ERASE;  end
      ST_COMMIT: begin want_c = 1'b1; op_c = MOP_COMMIT; end
      ST_REEN:   begin want_c = 1'b1; op_c = MOP_REEN;   end
      ST_RD_REQ: begin
        want_c = 1'b1;
        op_c   = MOP_READ;
        addr_c = {addr_q, 1'b0} + BADDR_W'(bcnt);
      end
      default: ;
    endcase
  end

  assign mem_req    = want_c && !mem_busy;
  assign mem_op     = op_c;
  assign mem_addr   = addr_c;
  assign mem_wdata  = {wacc[7:0], wacc[15:8]};
  assign jump_valid = jump_q;
  assign jump_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_CMD;
      cmd_q   <= '0;
      addr_q  <= '0;
      dcnt    <= '0;
      wcnt    <= '0;
      bcnt    <= '0;
      wacc    <= '0;
      rbyte_q <= '0;
      jump_q  <= 1'b0;
    end else begin
      jump_q <= 1'b0;
      case (state)
        ST_CMD: begin
          if (take && rx_data != CH_CR) begin
            cmd_q <= rx_data;
            dcnt  <= '0;
            state <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (take) begin
            if (!hex_ok) begin
              state <= ST_CMD;
            end else begin
              addr_q <= {addr_q[ADDR_W-5:0], hex_val};
              dcnt   <= dcnt + 1'b1;
              if (dcnt == DCNT_W'(ADIG - 1)) state <= ST_ADDR_CR;
            end
          end
        end
        ST_ADDR_CR: begin
          if (take) begin
            if (rx_data != CH_CR) begin
              state <= ST_CMD;
            end else begin
              case (cmd_q)
                LTR_GO: begin
                  jump_q <= 1'b1;
                  state  <= ST_CMD;
                end
                LTR_READ: begin
                  bcnt  <= '0;
                  state <= ST_RD_REQ;
                end
                LTR_WRITE: begin
                  wcnt  <= '0;
                  dcnt  <= '0;
                  state <= ST_DATA;
                end
                LTR_ERASE: state <= ST_ERASE;
                default:   state <= ST_CMD;
              endcase
            end
          end
        end
        ST_DATA: begin
          if (take) begin
            if (!hex_ok) begin
              state <= ST_CMD;
            end else begin
              wacc <= {wacc[11:0], hex_val};
              if (dcnt == DCNT_W'(3)) begin
                dcnt  <= '0;
                state <= ST_LOAD;
              end else begin
                dcnt <= dcnt + 1'b1;
              end
            end
          end
        end
        ST_LOAD: begin
          if (!mem_busy) begin
            if (wcnt == WCNT_W'(PAGE_WORDS - 1)) begin
              state <= ST_DATA_CR;
            end else begin
              wcnt  <= wcnt + 1'b1;
              state <= ST_DATA;
            end
          end
        end
        ST_DATA_CR: begin
          if (take) state <= (rx_data == CH_CR) ? ST_COMMIT : ST_CMD;
        end
        ST_ERASE, ST_COMMIT: begin
          if (!mem_busy) state <= ST_REEN;
        end
        ST_REEN: begin
          if (!mem_busy) state <= ST_DOT;
        end
        ST_RD_REQ: begin
          if (!mem_busy) state <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          rbyte_q <= mem_rdata;
          state   <= ST_TX_HI;
        end
        ST_TX_HI: begin
          if (tx_ready) state <= ST_TX_LO;
        end
        ST_TX_LO: begin
          if (tx_ready) begin
            if (bcnt == BCNT_W'(PAGE_BYTES - 1)) begin
              state <= ST_DOT;
            end else begin
              bcnt  <= bcnt + 1'b1;
              state <= ST_RD_REQ;
            end
          end
        end
        ST_DOT: begin
          if (tx_ready) state <= ST_CMD;
        end
        default: state <= ST_CMD;
      endcase
    end
  end

endmodule

// File: rtl/hexpage_cmd_engine_chk.sv
module hexpage_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       mem_req,
  input logic       mem_busy,
  input logic       jump_valid
);
  // R11
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_busy);

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9
  jump_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> !jump_valid);

  // R13
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (!tx_valid && !mem_req));

  // R5
  tx_charset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data inside {[8'h30:8'h39], [8'h41:8'h46], 8'h2E}));
endmodule

bind hexpage_cmd_engine hexpage_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready), .mem_req(mem_req),
  .mem_busy(mem_busy), .jump_valid(jump_valid)
);

// File: tb/hexpage_cmd_engine_bench.sv
module hexpage_cmd_engine_bench;
  localparam int CLK_P = 10;
  localparam int PW    = 8;
  localparam int PB    = 2 * PW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        mem_req;
  logic [2:0]  mem_op;
  logic [16:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_busy;
  logic        jump_valid;
  logic [15:0] jump_addr;

  always #(CLK_P/2) clk = ~clk;

  hexpage_cmd_engine #(.PAGE_WORDS(PW), .ADDR_W(16)) u_hexpage_cmd_engine (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_busy(mem_busy),
    .jump_valid(jump_valid), .jump_addr(jump_addr)
  );

  int  busy_cnt = 0;
  bit  busy_start = 1'b0;
  int  busy_viol = 0;
  assign mem_busy = (busy_cnt != 0);

  logic [7:0]  memb [int];
  logic [7:0]  pbuf [int];
  logic [7:0]  tx_log[$], exp_tx[$];
  logic [35:0] op_log[$], exp_ops[$];
  logic [15:0] jmp_log[$], exp_jmp[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0] bad_set [9] = '{8'h2F, 8'h3A, 8'h40, 8'h47, 8'h61, 8'h66, 8'h20, 8'h2E, 8'h5A};

  function automatic logic [7:0] rd(input int a);
    if (memb.exists(a)) return memb[a];
    return 8'(a * 37 + 11);
  endfunction

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h37 + {4'h0, n};
  endfunction

  function automatic logic [35:0] mkop(input logic [2:0] op, input logic [16:0] a,
                                       input logic [15:0] d);
    return {op, a, d};
  endfunction

  // memory model and stream monitors, all sampled mid-cycle
  always @(negedge clk) begin
    busy_start = 1'b0;
    if (rst_n) begin
      tx_ready = ($urandom % 4) != 0;
      if (tx_valid && tx_ready) tx_log.push_back(tx_data);
      if (jump_valid) jmp_log.push_back(jump_addr);
      if (mem_req && mem_busy) busy_viol++;
      if (mem_req) begin
        op_log.push_back(mkop(mem_op, mem_addr, (mem_op == 3'd2) ? mem_wdata : 16'h0));
        case (mem_op)
          3'd1: for (int i = 0; i < PB; i++) memb[int'(mem_addr) + i] = 8'hFF;
          3'd2: begin
            pbuf[int'(mem_addr)]     = mem_wdata[7:0];
            pbuf[int'(mem_addr) + 1] = mem_wdata[15:8];
          end
          3'd3: begin
            foreach (pbuf[k]) memb[k] = pbuf[k];
            pbuf.delete();
          end
          3'd5: mem_rdata = rd(int'(mem_addr));
          default: ;
        endcase
        busy_start = (mem_op == 3'd1) || (mem_op == 3'd3);
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else if (busy_start) busy_cnt <= 2 + int'($urandom % 10);
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    else if ($urandom % 16 == 0) busy_cnt <= 1 + int'($urandom % 2);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R13 watchdog: actual %0d cycles without completion, expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input bit ok, input string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = c;
    #1;
    while (!rx_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
  endtask

  task automatic put(input logic [7:0] c);
    if ($urandom % 6 == 0) send(8'h0A);
    if ($urandom % 5 == 0) repeat (1 + $urandom % 3) @(negedge clk);
    send(c);
  endtask

  task automatic put_byte(input logic [7:0] b);
    put(hx(b[7:4]));
    put(hx(b[3:0]));
  endtask

  task automatic put_hex16(input logic [15:0] v);
    put_byte(v[15:8]);
    put_byte(v[7:0]);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!rx_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_all();
    tx_log.delete();  exp_tx.delete();
    op_log.delete();  exp_ops.delete();
    jmp_log.delete(); exp_jmp.delete();
  endtask

  task automatic verify(input string tag);
    bit ok;
    string a, e;
    ok = (tx_log.size() == exp_tx.size());
    if (ok) foreach (exp_tx[i]) if (tx_log[i] !== exp_tx[i]) ok = 0;
    a = ""; e = "";
    foreach (tx_log[i]) a = {a, string'(tx_log[i])};
    foreach (exp_tx[i]) e = {e, string'(exp_tx[i])};
    chk(tag, ok, $sformatf("reply actual \"%s\" expected \"%s\"", a, e));
    ok = (op_log.size() == exp_ops.size());
    if (ok) foreach (exp_ops[i]) if (op_log[i] !== exp_ops[i]) ok = 0;
    chk(tag, ok, $sformatf("memory ops actual %0d [%h] expected %0d [%h]", op_log.size(),
        (op_log.size() != 0) ? op_log[op_log.size()-1] : 36'h0, exp_ops.size(),
        (exp_ops.size() != 0) ? exp_ops[exp_ops.size()-1] : 36'h0));
    ok = (jmp_log.size() == exp_jmp.size());
    if (ok) foreach (exp_jmp[i]) if (jmp_log[i] !== exp_jmp[i]) ok = 0;
    chk(tag, ok, $sformatf("jumps actual %0d (%h) expected %0d (%h)", jmp_log.size(),
        (jmp_log.size() != 0) ? jmp_log[0] : 16'h0, exp_jmp.size(),
        (exp_jmp.size() != 0) ? exp_jmp[0] : 16'h0));
    clear_all();
  endtask

  function automatic logic [7:0] bad_char();
    return bad_set[$urandom % 9];
  endfunction

  task automatic do_erase(input logic [15:0] a);
    exp_ops.push_back(mkop(3'd1, {a, 1'b0}, 16'h0));
    exp_ops.push_back(mkop(3'd4, {a, 1'b0}, 16'h0));
    exp_tx.push_back(8'h2E);
    put(8'h65); put_hex16(a); put(8'h0D);
    wait_idle();
    verify("R8 erase");
  endtask

  task automatic do_read(input logic [15:0] a);
    for (int i = 0; i < PB; i++) begin
      logic [16:0] ba;
      logic [7:0]  b;
      ba = {a, 1'b0} + 17'(i);
      b  = rd(int'(ba));
      exp_ops.push_back(mkop(3'd5, ba, 16'h0));
      exp_tx.push_back(hx(b[7:4]));
      exp_tx.push_back(hx(b[3:0]));
    end
    exp_tx.push_back(8'h2E);
    put(8'h72); put_hex16(a); put(8'h0D);
    wait_idle();
    verify("R5 R12 read");
  endtask

  // mode 0: complete, 1: bad digit inside word j, 2: bad closing character
  task automatic do_write(input logic [15:0] a, input int mode, input int j);
    put(8'h77); put_hex16(a); put(8'h0D);
    for (int k = 0; k < PW; k++) begin
      logic [15:0] w;
      logic [15:0] wa;
      w = 16'($urandom);
      if (mode == 1 && k == j) begin
        int m;
        m = $urandom % 4;
        for (int d = 0; d < m; d++) put(hx(4'($urandom)));
        put(bad_char());
        break;
      end
      wa = a + 16'(k);
      exp_ops.push_back(mkop(3'd2, {wa, 1'b0}, w));
      put_byte(w[7:0]);
      put_byte(w[15:8]);
    end
    if (mode == 0) begin
      exp_ops.push_back(mkop(3'd3, {a, 1'b0}, 16'h0));
      exp_ops.push_back(mkop(3'd4, {a, 1'b0}, 16'h0));
      exp_tx.push_back(8'h2E);
      put(8'h0D);
    end else if (mode == 2) begin
      put(bad_char());
    end
    wait_idle();
    if (mode == 0)      verify("R6 R8 write");
    else if (mode == 1) verify("R3 R6 write bad digit");
    else                verify("R7 write no closing CR");
  endtask

  task automatic do_go(input logic [15:0] a, input string tag);
    exp_jmp.push_back(a);
    put(8'h67); put_hex16(a); put(8'h0D);
    wait_idle();
    verify(tag);
  endtask

  task automatic do_unknown(input logic [15:0] a);
    logic [7:0] l [5] = '{8'h71, 8'h78, 8'h45, 8'h57, 8'h52};
    put(l[$urandom % 5]); put_hex16(a); put(8'h0D);
    wait_idle();
    verify("R10 unknown letter");
  endtask

  task automatic do_bad_addr();
    logic [7:0] l [4] = '{8'h65, 8'h72, 8'h77, 8'h67};
    int k;
    k = $urandom % 4;
    put(l[$urandom % 4]);
    for (int d = 0; d < k; d++) put(hx(4'($urandom)));
    put(bad_char());
    wait_idle();
    verify("R3 bad address digit");
  endtask

  task automatic do_bad_cr(input logic [15:0] a);
    logic [7:0] l [4] = '{8'h65, 8'h72, 8'h77, 8'h67};
    put(l[$urandom % 4]); put_hex16(a);
    put(($urandom % 2 == 0) ? bad_char() : 8'h35);
    wait_idle();
    verify("R4 missing CR");
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 reset", rx_ready === 1'b1, $sformatf("rx_ready actual %b expected 1", rx_ready));
    chk("R13 reset", tx_valid === 1'b0, $sformatf("tx_valid actual %b expected 0", tx_valid));
    chk("R13 reset", mem_req === 1'b0, $sformatf("mem_req actual %b expected 0", mem_req));
    chk("R13 reset", jump_valid === 1'b0, $sformatf("jump_valid actual %b expected 0", jump_valid));
    clear_all();

    // R1 R2: carriage returns and line feeds in command position
    send(8'h0D); send(8'h0A); send(8'h0D);
    do_go(16'h1234, "R1 R2 go after CR and LF");
    // directed corners
    do_erase(16'h0040);
    do_write(16'h0040, 0, 0);
    do_read(16'h0040);
    do_read(16'hFFFC);
    do_write(16'h0100, 2, 0);
    do_write(16'h0200, 1, 0);
    do_write(16'h0300, 1, PW - 1);
    do_go(16'hFFFF, "R9 go max");
    do_go(16'h0000, "R9 go zero");

    for (int n = 0; n < 70; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      case ($urandom % 9)
        0: do_erase(a);
        1: do_read(a);
        2: do_write(a, 0, 0);
        3: do_go(a, "R9 go");
        4: do_unknown(a);
        5: do_bad_addr();
        6: do_bad_cr(a);
        7: do_write(a, 1, int'($urandom % PW));
        default: do_write(a, 2, 0);
      endcase
      if (n % 10 == 9) begin
        do_write(a, 0, 0);
        do_read(a);
      end
    end

    chk("R11 busy", busy_viol == 0, $sformatf("requests under busy actual %0d expected 0", busy_viol));
    summary();
    $finish;
  end
endmodule